// File: doc/BRIEF.md
# Variable-Rate Slot Request Controller

This block is the frame-by-frame pacing logic of a codec on an AC'97-style serial link. On every frame start it decides which playback slots should ask the controller for a sample in the next output frame. It also decides which capture slots carry a valid sample in the current input frame. For each requested playback slot, it then checks the tag bits that come back one frame later. The serial shifter, the converters and the sample datapath sit outside the block. The block only produces the active-low request vector, the capture tag vector and a per-slot underrun pulse.

In fixed-rate mode (variable rate off), every active playback slot requests a sample in every frame and every capture slot is tagged valid in every frame. In variable-rate mode, each stream (playback and capture) runs a phase accumulator clocked once per 48 kHz frame. The stream's programmed rate is added to its accumulator. Whenever the sum reaches 48000, 48000 is taken off and one sample is due. A full playback FIFO holds the playback stream back. Turning variable rate off forces both rate registers to 48000. The active playback slots are always slots 3 and 4 plus the slot pair chosen for the digital audio output stream.

Top module: `vrsr_ctrl`

Slot vectors are 12 bits wide. Bit 11 stands for slot 3, bit 10 for slot 4, and so on down to bit 2 for slot 12. Bits 1:0 map to no slot.

The register port has three selects:
- Select 0 is control. Data bit 0 is the variable-rate enable. Data bits 5:4 are the slot-pair assignment.
- Select 1 is the playback rate.
- Select 2 is the capture rate.
- Select 3 is ignored.

## Requirements
- R1: After reset, `slot_req_n` is 12'hFFF, `cap_tag` and `underrun` are 0, `vra_en` is 0 and both rates read 48000. The slot-pair assignment resets to 00.
- R2: With `vra_en` at 0, every frame start requests all active playback slots and tags slots 3 and 4 valid on `cap_tag` (12'hC00). `fifo_full` has no effect in this mode.
- R3: A control write with data bit 0 at 0 sets both rate registers to 48000. While `vra_en` is 0, rate writes are ignored. While `vra_en` is 1, rate writes take effect.
- R4: A rate write above 48000 stores 48000. Writes at or below 48000 are stored unchanged.
- R5: With `vra_en` at 1, each frame start adds the playback rate to the playback accumulator. If the sum is at least 48000, slots 3/4 and the assigned pair are requested and 48000 is subtracted. Otherwise nothing is requested. The accumulator starts from 0 when variable rate is enabled.
- R6: With `vra_en` at 1, the capture accumulator works the same way with the capture rate. Its firing sets `cap_tag` to 12'hC00, and otherwise `cap_tag` is 0.
- R7: With `vra_en` at 1, a frame start with `fifo_full` high requests nothing and leaves the playback accumulator unchanged.
- R8: The slot-pair assignment maps the digital-out pair onto request bits as follows: 00 → slots 3/4 (12'hC00), 01 → 7/8 (12'h0C0), 10 → 6/9 (12'h120), 11 → 10/11 (12'h018).
- R9: At a frame start, each slot requested at the previous frame start whose bit in `tag_in` is 0 pulses its `underrun` bit for exactly one cycle. No extra request is issued for it.
- R10: `slot_req_n` and `cap_tag` change only in the cycle after a frame start. Bits 1:0 of `slot_req_n` are always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 playback rate, 2 capture rate |
| reg_wdata | input | 16 | Register write data |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| tag_in | input | 12 | Tag bits received in the output frame now starting |
| fifo_full | input | 1 | Playback FIFO cannot accept another sample |
| slot_req_n | output | 12 | Active-low slot request vector |
| cap_tag | output | 12 | Capture-slot valid tags |
| underrun | output | 12 | One-cycle pulse per requested slot whose tag was missing |
| vra_en | output | 1 | Current variable-rate enable |
| play_rate | output | 16 | Current playback rate register |
| cap_rate | output | 16 | Current capture rate register |

## Verification
The assertions check the following on every cycle:
- both rates stay at 48000 while variable rate is off, and never exceed 48000;
- each accumulator stays below 48000;
- outputs hold between frame starts;
- underrun pulses only follow a frame start;
- fixed-rate frames request slots 3/4;
- a full FIFO in variable-rate mode yields no request.

Only the directed scenarios can show the exact pacing sequences for chosen rates, the freezing of credit under a full FIFO, the mapping of each slot-pair code, and which slots miss their tag.

// File: rtl/vrsr_pkg.sv
package vrsr_pkg;
  localparam int unsigned SLOT_W = 12;
  localparam int unsigned RATE_W = 16;
  localparam logic [RATE_W-1:0] FULL_RATE = 16'd48000;

  localparam logic [SLOT_W-1:0] FRONT_MASK  = 12'hC00;
  localparam logic [SLOT_W-1:0] UNUSED_MASK = 12'h003;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PLAY = 2'd1,
    SEL_CAP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [SLOT_W-1:0] pair_mask(input logic [1:0] code);
    case (code)
      2'b00:   pair_mask = 12'hC00;
      2'b01:   pair_mask = 12'h0C0;
      2'b10:   pair_mask = 12'h120;
      default: pair_mask = 12'h018;
    endcase
  endfunction
endpackage

// File: rtl/vrsr_regs.sv
module vrsr_regs
  import vrsr_pkg::*;
#(
  parameter int unsigned          RW   = RATE_W,
  parameter logic [RW-1:0]        FULL = FULL_RATE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [RW-1:0] wdata,
  output logic          vra,
  output logic [1:0]    pair_sel,
  output logic [RW-1:0] play_rate,
  output logic [RW-1:0] cap_rate
);
  logic          vra_q, vra_d;
  logic [1:0]    pair_q, pair_d;
  logic [RW-1:0] play_q, play_d, cap_q, cap_d;
  logic [RW-1:0] clamped;

  assign clamped = (wdata > FULL) ? FULL : wdata;

  always_comb begin
    vra_d  = vra_q;
    pair_d = pair_q;
    play_d = play_q;
    cap_d  = cap_q;
    case (sel)
      SEL_CTRL: begin
        vra_d  = wdata[0];
        pair_d = wdata[5:4];
        if (!wdata[0]) begin
          play_d = FULL;
          cap_d  = FULL;
        end
      end
      SEL_PLAY: if (vra_q) play_d = clamped;
      SEL_CAP:  if (vra_q) cap_d  = clamped;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vra_q  <= 1'b0;
      pair_q <= 2'b00;
      play_q <= FULL;
      cap_q  <= FULL;
    end else if (wr) begin
      vra_q  <= vra_d;
      pair_q <= pair_d;
      play_q <= play_d;
      cap_q  <= cap_d;
    end
  end

  assign vra       = vra_q;
  assign pair_sel  = pair_q;
  assign play_rate = play_q;
  assign cap_rate  = cap_q;

  // R3: rates pinned to full rate whenever variable rate is off
  assert_rates_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vra_q |-> (play_q == FULL && cap_q == FULL));

  // R4: stored rates never exceed full rate
  assert_rate_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (play_q <= FULL) && (cap_q <= FULL));
endmodule

// File: rtl/vrsr_pacer.sv
module vrsr_pacer
  import vrsr_pkg::*;
#(
  parameter int unsigned   RW   = RATE_W,
  parameter logic [RW-1:0] FULL = FULL_RATE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [RW-1:0] rate,
  output logic          fire
);
  logic [RW-1:0] acc_q, acc_d;
  logic [RW:0]   sum;
  logic [RW:0]   wrapped;

  assign sum     = {1'b0, acc_q} + {1'b0, rate};
  assign fire    = (sum >= {1'b0, FULL});
  assign wrapped = sum - {1'b0, FULL};

  always_comb begin
    acc_d = acc_q;
    if (clr)       acc_d = '0;
    else if (tick) acc_d = fire ? wrapped[RW-1:0] : sum[RW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           acc_q <= '0;
    else if (clr || tick) acc_q <= acc_d;
  end

  // R5: phase stays strictly below one full frame of credit
  assert_acc_below_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < FULL);
endmodule

// File: rtl/vrsr_ctrl.sv
module vrsr_ctrl
  import vrsr_pkg::*;
#(
  parameter int unsigned       RW   = RATE_W,
  parameter logic [RW-1:0]     FULL = FULL_RATE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [RW-1:0]     reg_wdata,
  input  logic              frame_start,
  input  logic [SLOT_W-1:0] tag_in,
  input  logic              fifo_full,
  output logic [SLOT_W-1:0] slot_req_n,
  output logic [SLOT_W-1:0] cap_tag,
  output logic [SLOT_W-1:0] underrun,
  output logic              vra_en,
  output logic [RW-1:0]     play_rate,
  output logic [RW-1:0]     cap_rate
);
  localparam int unsigned NSTREAM = 2;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [1:0] pair_sel;

  vrsr_regs #(.RW(RW), .FULL(FULL)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .vra(vra_en), .pair_sel(pair_sel),
    .play_rate(play_rate), .cap_rate(cap_rate)
  );

  logic [RW-1:0]      rate_v [NSTREAM];
  logic [NSTREAM-1:0] tick_v, fire_v;

  assign rate_v[0] = play_rate;
  assign rate_v[1] = cap_rate;
  assign tick_v[0] = frame_start & vra_en & ~fifo_full;
  assign tick_v[1] = frame_start & vra_en;

  for (genvar s = 0; s < NSTREAM; s++) begin : g_pacer
    vrsr_pacer #(.RW(RW), .FULL(FULL)) u_pacer (
      .clk(clk), .rst_n(rst_core_n), .clr(~vra_en), .tick(tick_v[s]),
      .rate(rate_v[s]), .fire(fire_v[s])
    );
  end

  logic              play_due, cap_due;
  logic [SLOT_W-1:0] req_mask;
  logic [SLOT_W-1:0] req_n_q, req_n_d, pend_q, pend_d;
  logic [SLOT_W-1:0] cap_q, cap_d, und_q, und_d;

  assign play_due = vra_en ? (fire_v[0] & ~fifo_full) : 1'b1;
  assign cap_due  = vra_en ? fire_v[1] : 1'b1;
  assign req_mask = play_due ? (FRONT_MASK | pair_mask(pair_sel)) : '0;

  always_comb begin
    req_n_d = ~req_mask | UNUSED_MASK;
    pend_d  = req_mask;
    cap_d   = cap_due ? FRONT_MASK : '0;
    und_d   = frame_start ? (pend_q & ~tag_in) : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      req_n_q <= '1;
      pend_q  <= '0;
      cap_q   <= '0;
    end else if (frame_start) begin
      req_n_q <= req_n_d;
      pend_q  <= pend_d;
      cap_q   <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) und_q <= '0;
    else             und_q <= und_d;
  end

  assign slot_req_n = req_n_q;
  assign cap_tag    = cap_q;
  assign underrun   = und_q;

  // R10: outputs hold between frame starts
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !frame_start |=> ($stable(slot_req_n) && $stable(cap_tag)));

  // R2: fixed-rate frames always request the front pair and tag capture
  assert_fixed_all_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frame_start && !vra_en) |=> (slot_req_n[11:10] == 2'b00 && cap_tag[11:10] == 2'b11));

  // R7: full FIFO in variable-rate mode withholds every request
  assert_full_no_req_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frame_start && vra_en && fifo_full) |=> (&slot_req_n));

  // R9: underrun only pulses right after a frame start
  assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|underrun) |-> $past(frame_start));
endmodule

// File: tb/sim_vrsr_ctrl.sv
module sim_vrsr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FULLR = 48000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic        frame_start;
  logic [11:0] tag_in;
  logic        fifo_full;
  logic [11:0] slot_req_n, cap_tag, underrun;
  logic        vra_en;
  logic [15:0] play_rate, cap_rate;

  vrsr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .tag_in(tag_in),
    .fifo_full(fifo_full), .slot_req_n(slot_req_n), .cap_tag(cap_tag),
    .underrun(underrun), .vra_en(vra_en), .play_rate(play_rate),
    .cap_rate(cap_rate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ncmp = 0;
  int nbad = 0;
  bit done = 1'b0;

  // bench model state
  bit          m_vra;
  logic [1:0]  m_pair;
  int          m_pr, m_cr, m_pacc, m_cacc;
  logic [11:0] m_prev;

  function automatic logic [11:0] exp_pair(input logic [1:0] c);
    case (c)
      2'b00:   return 12'hC00;
      2'b01:   return 12'h0C0;
      2'b10:   return 12'h120;
      default: return 12'h018;
    endcase
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    int v;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    v = (int'(d) > FULLR) ? FULLR : int'(d);
    if (sel == 2'd0) begin
      m_vra = d[0]; m_pair = d[5:4];
      if (!d[0]) begin m_pr = FULLR; m_cr = FULLR; m_pacc = 0; m_cacc = 0; end
    end else if (sel == 2'd1 && m_vra) m_pr = v;
    else if (sel == 2'd2 && m_vra) m_cr = v;
  endtask

  task automatic frame(input logic [11:0] tg, input bit ff,
                       input string rq_req, input string rq_cap);
    bit preq, cf;
    logic [11:0] mask, e_req, e_und, e_cap;
    if (m_vra) begin
      preq = 1'b0;
      if (!ff) begin
        preq = (m_pacc + m_pr) >= FULLR;
        m_pacc = preq ? m_pacc + m_pr - FULLR : m_pacc + m_pr;
      end
      cf = (m_cacc + m_cr) >= FULLR;
      m_cacc = cf ? m_cacc + m_cr - FULLR : m_cacc + m_cr;
    end else begin
      preq = 1'b1; cf = 1'b1;
    end
    mask  = preq ? (12'hC00 | exp_pair(m_pair)) : 12'h000;
    e_req = ~mask | 12'h003;
    e_und = m_prev & ~tg;
    e_cap = cf ? 12'hC00 : 12'h000;
    m_prev = mask;
    @(negedge clk);
    frame_start = 1'b1; tag_in = tg; fifo_full = ff;
    @(negedge clk);
    frame_start = 1'b0;
    check(rq_req, "slot_req_n", slot_req_n, e_req);
    check(rq_cap, "cap_tag", cap_tag, e_cap);
    check("R9", "underrun", underrun, e_und);
    @(negedge clk);
    check("R9", "underrun cleared", underrun, 12'h000);
  endtask

  task automatic t_reset;
    check("R1", "slot_req_n", slot_req_n, 12'hFFF);
    check("R1", "cap_tag", cap_tag, 12'h000);
    check("R1", "underrun", underrun, 12'h000);
    check("R1", "vra_en", vra_en, 1'b0);
    check("R1", "play_rate", play_rate, FULLR);
    check("R1", "cap_rate", cap_rate, FULLR);
  endtask

  task automatic t_fixed;
    wr(2'd0, 16'h0010);
    frame(12'hFFF, 1'b1, "R2", "R2");
    frame(12'hFFF, 1'b1, "R2", "R2");
    frame(12'hFFF, 1'b0, "R2", "R2");
  endtask

  task automatic t_pairs;
    for (int a = 0; a < 4; a++) begin
      wr(2'd0, 16'(a << 4));
      frame(12'hFFF, 1'b0, "R8", "R2");
    end
  endtask

  task automatic t_vra_off;
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd1000);
    check("R3", "play_rate accepted", play_rate, 1000);
    wr(2'd2, 16'd2000);
    check("R3", "cap_rate accepted", cap_rate, 2000);
    wr(2'd0, 16'h0000);
    check("R3", "play_rate forced", play_rate, FULLR);
    check("R3", "cap_rate forced", cap_rate, FULLR);
    wr(2'd1, 16'd1000);
    check("R3", "play_rate write ignored", play_rate, FULLR);
  endtask

  task automatic t_clamp;
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd50000);
    check("R4", "play_rate clamp", play_rate, FULLR);
    wr(2'd2, 16'hFFFF);
    check("R4", "cap_rate clamp", cap_rate, FULLR);
    wr(2'd1, 16'd47999);
    check("R4", "play_rate exact", play_rate, 47999);
  endtask

  task automatic t_pace;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd24000);
    wr(2'd2, 16'd16000);
    for (int i = 0; i < 6; i++) frame(12'hFFF, 1'b0, "R5", "R6");
    wr(2'd1, 16'd44100);
    for (int i = 0; i < 5; i++) frame(12'hFFF, 1'b0, "R5", "R6");
  endtask

  task automatic t_fifo;
    wr(2'd1, 16'd24000);
    for (int i = 0; i < 3; i++) frame(12'hFFF, 1'b1, "R7", "R6");
    for (int i = 0; i < 3; i++) frame(12'hFFF, 1'b0, "R7", "R6");
  endtask

  task automatic t_underrun;
    wr(2'd0, 16'h0011);
    wr(2'd1, 16'd48000);
    frame(12'hFFF, 1'b0, "R9", "R6");
    frame(12'h000, 1'b0, "R9", "R6");
    frame(12'h400, 1'b0, "R9", "R6");
    frame(12'h0C0, 1'b0, "R9", "R6");
  endtask

  task automatic t_hold;
    logic [11:0] r0, c0;
    frame(12'hFFF, 1'b0, "R10", "R6");
    r0 = slot_req_n; c0 = cap_tag;
    check("R10", "unused bits", {20'd0, slot_req_n[1:0]}, 2'b11);
    wr(2'd1, 16'd1000);
    @(negedge clk);
    tag_in = 12'h000; fifo_full = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "slot_req_n held", slot_req_n, r0);
    check("R10", "cap_tag held", cap_tag, c0);
    fifo_full = 1'b0; tag_in = 12'hFFF;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    frame_start = 1'b0; tag_in = 12'hFFF; fifo_full = 1'b0;
    m_vra = 1'b0; m_pair = 2'b00; m_pr = FULLR; m_cr = FULLR;
    m_pacc = 0; m_cacc = 0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fixed;
    t_pairs;
    t_vra_off;
    t_clamp;
    t_pace;
    t_fifo;
    t_underrun;
    t_hold;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ncmp++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end
endmodule